// File: doc/BRIEF.md
# Key-Protected Watchdog Timer with Early-Warning Stage

This block is a watchdog timer for a system that counts time in ticks of a slow reference (nominally 32 kHz). The ticks arrive as a one-cycle enable on the system clock. Software reaches it through a plain 32-bit register port: a write strobe, an address, write data and combinational read data. Software arms the watchdog and then has to keep proving it is alive by writing one magic word to the kick register. If the kicks stop, the block requests a reset. The request drives an internal output and an optional external pin whose active level software selects.

Every register that stores state carries a key field, so a stray write cannot change the register. A write with a wrong key is dropped and leaves a sticky error flag behind. In two-stage mode the programmed length runs twice. The first expiry raises an interrupt, which gives software a chance to react. The second expiry requests the reset. A command register requests a reset at once. A separate line-reset register drives a vector of individually controlled reset outputs, also behind a key.

Top module: `wdog_keyed`

## Requirements
- R1: A write to the control register (offset 0x00) takes effect only when bits [31:24] hold 0x22. The stored fields are: arm at bit 0, pin active-high at bit 1, pin drive enable at bit 2, interrupt enable at bit 3, re-arm after reset at bit 4 and two-stage mode at bit 6. A read returns them at the same positions, with bit 5 and bits [30:7] reading zero.
- R2: A write with a wrong key to the control, length or line-reset register leaves that register unchanged and sets a sticky key-error flag. The flag reads back at bit 31 of the control register, and only reset clears it.
- R3: A write to the length register (offset 0x04) takes effect only when bits [4:0] hold 0x08. The count sits at bits [5 +: LEN_W], and a read returns the count with 0x08 in bits [4:0]. A new count does not touch a countdown in progress: it is used from the next kick or arming.
- R4: Once armed with count N (N ≥ 1), with no kick, the reset request rises on the N×UNIT_TICKS-th tick after the arming write. A tick that arrives in the same cycle as the arming write is not counted. Without the two-stage setting the first expiry goes straight to reset.
- R5: Writing exactly 0x1971 to the kick register (offset 0x08) restarts the countdown from the stored count. Any other value has no effect. The register reads as zero.
- R6: The reset request stays high for HOLD_TICKS ticks (16) after it rises, then falls. In the same cycle the arm bit clears, unless re-arm is set.
- R7: With two-stage mode and interrupt enable both set, the first expiry raises the interrupt and the count starts again. A second expiry with no kick raises the reset request and drops the interrupt. A valid kick, or a keyed write that clears arm, drops the interrupt and returns the count to the first stage. The interrupt never rises when either setting is clear.
- R8: Writing exactly 0x1209 to the command register (offset 0x14) raises the reset request on the next cycle, whether or not the watchdog is armed. Other values are ignored.
- R9: The external pin shows the reset request at the selected level when pin drive is enabled, and otherwise sits at its inactive level. Active-high means the pin is 1 during the request; active-low means the pin is 0 during the request.
- R10: A write to the line-reset register (offset 0x18) takes effect only when bits [31:24] hold 0x88. Each bit i below NRST sets (1) or releases (0) output line i. A read returns the current state of the lines.
- R11: With re-arm set, the arm bit survives the end of the reset hold and the countdown restarts from the stored count.
- R12: After reset every control field is zero, the count is all ones, the key-error flag is clear, and all outputs are inactive. Because the pin starts active-low, it reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base tick enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rst_req_o | output | 1 | Internal reset request, active high |
| ext_rst_o | output | 1 | External reset pin, programmable level |
| irq_o | output | 1 | Early-warning interrupt |
| line_rst_o | output | NRST | Software-controlled reset lines |

## Verification
The bench builds the block with UNIT_TICKS=4 and LEN_W=6 and keeps HOLD_TICKS=16 and NRST=8. With these values a count of 2 expires in 8 ticks, so every expiry, both stages of two-stage mode, the full 16-tick hold and a re-arm cycle all fit in a few hundred ticks. The expiry and hold boundaries are checked on the exact tick, one tick before and on the edge itself. A short count and a longer count of 4 show that a length change waits for the next arming.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Register offsets; software decodes these, so they are fixed
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_LEN   = 8'h04;
  localparam logic [7:0] OFF_KICK  = 8'h08;
  localparam logic [7:0] OFF_CMD   = 8'h14;
  localparam logic [7:0] OFF_LINES = 8'h18;

  // Key and magic values
  localparam logic [7:0]  CTRL_KEY   = 8'h22;
  localparam logic [4:0]  LEN_KEY    = 5'h08;
  localparam logic [7:0]  LINES_KEY  = 8'h88;
  localparam logic [31:0] KICK_MAGIC = 32'h0000_1971;
  localparam logic [31:0] CMD_MAGIC  = 32'h0000_1209;

  // Control field bit positions
  localparam int B_ARM  = 0;
  localparam int B_POLH = 1;
  localparam int B_PIN  = 2;
  localparam int B_IRQ  = 3;
  localparam int B_AUTO = 4;
  localparam int B_DUAL = 6;

  typedef struct packed {
    logic dual;
    logic rearm;
    logic irq_en;
    logic pin_en;
    logic pol_hi;
    logic arm;
  } wd_ctrl_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 6,
  parameter int NRST   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              hold_done,
  output wd_ctrl_t          ctrl_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [NRST-1:0]   lines_q,
  output logic              key_err_q,
  output logic              kick,
  output logic              start,
  output logic              stop,
  output logic              cmd_rst
);

  localparam int LEN_PAD  = 32 - LEN_W - 5;
  localparam int LINE_PAD = 32 - NRST;

  logic hit_ctrl, hit_len, hit_kick, hit_cmd, hit_lines;
  logic ok_ctrl, ok_len, ok_lines;
  logic wr_ctrl;

  assign hit_ctrl  = bus_addr == ADDR_W'(OFF_CTRL);
  assign hit_len   = bus_addr == ADDR_W'(OFF_LEN);
  assign hit_kick  = bus_addr == ADDR_W'(OFF_KICK);
  assign hit_cmd   = bus_addr == ADDR_W'(OFF_CMD);
  assign hit_lines = bus_addr == ADDR_W'(OFF_LINES);

  assign ok_ctrl  = bus_wdata[31:24] == CTRL_KEY;
  assign ok_len   = bus_wdata[4:0]   == LEN_KEY;
  assign ok_lines = bus_wdata[31:24] == LINES_KEY;

  assign wr_ctrl = bus_we && hit_ctrl && ok_ctrl;
  assign kick    = bus_we && hit_kick && (bus_wdata == KICK_MAGIC);
  assign cmd_rst = bus_we && hit_cmd  && (bus_wdata == CMD_MAGIC);
  assign start   = wr_ctrl && bus_wdata[B_ARM] && !ctrl_q.arm;
  assign stop    = wr_ctrl && !bus_wdata[B_ARM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      len_q     <= '1;
      lines_q   <= '0;
      key_err_q <= 1'b0;
    end else begin
      if (bus_we && hit_ctrl) begin
        if (ok_ctrl) begin
          ctrl_q.arm    <= bus_wdata[B_ARM];
          ctrl_q.pol_hi <= bus_wdata[B_POLH];
          ctrl_q.pin_en <= bus_wdata[B_PIN];
          ctrl_q.irq_en <= bus_wdata[B_IRQ];
          ctrl_q.rearm  <= bus_wdata[B_AUTO];
          ctrl_q.dual   <= bus_wdata[B_DUAL];
        end else begin
          key_err_q <= 1'b1;
        end
      end
      if (bus_we && hit_len) begin
        if (ok_len) len_q <= bus_wdata[5 +: LEN_W];
        else        key_err_q <= 1'b1;
      end
      if (bus_we && hit_lines) begin
        if (ok_lines) lines_q <= bus_wdata[NRST-1:0];
        else          key_err_q <= 1'b1;
      end
      // End of a reset hold disarms unless re-arm is set; wins over a write
      if (hold_done && !ctrl_q.rearm) ctrl_q.arm <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)
      bus_rdata = {key_err_q, 24'd0, ctrl_q.dual, 1'b0, ctrl_q.rearm,
                   ctrl_q.irq_en, ctrl_q.pin_en, ctrl_q.pol_hi, ctrl_q.arm};
    else if (hit_len)
      bus_rdata = {{LEN_PAD{1'b0}}, len_q, LEN_KEY};
    else if (hit_lines)
      bus_rdata = {{LINE_PAD{1'b0}}, lines_q};
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int UNIT_TICKS = 512,
  parameter int LEN_W      = 6,
  parameter int HOLD_TICKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_en,
  input  logic             dual_arm,
  input  logic [LEN_W-1:0] len,
  input  logic             load,
  input  logic             stop,
  input  logic             cmd_rst,
  output logic             rst_req,
  output logic             irq,
  output logic             hold_done
);

  localparam int PRE_W  = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam int HOLD_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(UNIT_TICKS - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_TICKS - 1);

  logic [PRE_W-1:0]  pre_q;
  logic [LEN_W-1:0]  units_q;
  logic [HOLD_W-1:0] hcnt_q;
  logic              second_q, irq_q, hold_q;
  logic              pre_wrap, unit_last;

  assign pre_wrap  = pre_q == PRE_LAST;
  assign unit_last = units_q <= LEN_W'(1);
  assign hold_done = hold_q && tick && (hcnt_q == HOLD_LAST);
  assign rst_req   = hold_q;
  assign irq       = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      units_q  <= '0;
      hcnt_q   <= '0;
      second_q <= 1'b0;
      irq_q    <= 1'b0;
      hold_q   <= 1'b0;
    end else if (hold_q) begin
      if (tick) begin
        if (hold_done) begin
          hold_q  <= 1'b0;
          hcnt_q  <= '0;
          pre_q   <= '0;
          units_q <= len;
        end else begin
          hcnt_q <= hcnt_q + 1'b1;
        end
      end
    end else if (cmd_rst) begin
      hold_q   <= 1'b1;
      hcnt_q   <= '0;
      irq_q    <= 1'b0;
      second_q <= 1'b0;
    end else if (stop) begin
      pre_q    <= '0;
      irq_q    <= 1'b0;
      second_q <= 1'b0;
    end else if (load) begin
      pre_q    <= '0;
      units_q  <= len;
      irq_q    <= 1'b0;
      second_q <= 1'b0;
    end else if (run_en && tick) begin
      if (!pre_wrap) begin
        pre_q <= pre_q + 1'b1;
      end else begin
        pre_q <= '0;
        if (!unit_last) begin
          units_q <= units_q - 1'b1;
        end else if (dual_arm && !second_q) begin
          second_q <= 1'b1;
          irq_q    <= 1'b1;
          units_q  <= len;
        end else begin
          hold_q   <= 1'b1;
          hcnt_q   <= '0;
          irq_q    <= 1'b0;
          second_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = 6,
  parameter int UNIT_TICKS = 512,
  parameter int HOLD_TICKS = 16,
  parameter int NRST       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req_o,
  output logic              ext_rst_o,
  output logic              irq_o,
  output logic [NRST-1:0]   line_rst_o
);

  wd_ctrl_t         ctrl_q;
  logic [LEN_W-1:0] len_q;
  logic             key_err_q;
  logic             kick, start, stop, cmd_rst, hold_done;
  logic             dual_arm, pin_act;

  assign dual_arm = ctrl_q.dual && ctrl_q.irq_en;

  wdog_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NRST(NRST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hold_done (hold_done),
    .ctrl_q    (ctrl_q),
    .len_q     (len_q),
    .lines_q   (line_rst_o),
    .key_err_q (key_err_q),
    .kick      (kick),
    .start     (start),
    .stop      (stop),
    .cmd_rst   (cmd_rst)
  );

  wdog_timer #(.UNIT_TICKS(UNIT_TICKS), .LEN_W(LEN_W), .HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_i),
    .run_en    (ctrl_q.arm),
    .dual_arm  (dual_arm),
    .len       (len_q),
    .load      (kick || start),
    .stop      (stop),
    .cmd_rst   (cmd_rst),
    .rst_req   (rst_req_o),
    .irq       (irq_o),
    .hold_done (hold_done)
  );

  assign pin_act   = ctrl_q.pin_en && rst_req_o;
  assign ext_rst_o = ctrl_q.pol_hi ? pin_act : !pin_act;

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int ADDR_W = 8,
  parameter int NRST   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              rst_req_o,
  input logic              irq_o,
  input logic [NRST-1:0]   line_rst_o,
  input logic              arm,
  input logic              rearm,
  input logic              dual_arm,
  input logic              key_err
);

  logic lines_wr, cmd_hit, ctrl_bad;
  assign lines_wr = bus_we && bus_addr == ADDR_W'(8'h18) && bus_wdata[31:24] == 8'h88;
  assign cmd_hit  = bus_we && bus_addr == ADDR_W'(8'h14) && bus_wdata == 32'h1209;
  assign ctrl_bad = bus_we && bus_addr == ADDR_W'(8'h00) && bus_wdata[31:24] != 8'h22;

  assert_lines_keyed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lines_wr |=> $stable(line_rst_o));

  assert_cmd_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> rst_req_o);

  assert_irq_needs_dual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(dual_arm));

  assert_req_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(cmd_hit || arm));

  assert_release_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req_o) |-> $past(tick_i));

  assert_disarm_after_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rst_req_o) && !$past(rearm)) |-> !arm);

  assert_bad_key_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_bad |=> key_err);

  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_err |=> key_err);

endmodule

bind wdog_keyed wdog_keyed_chk #(.ADDR_W(ADDR_W), .NRST(NRST)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .rst_req_o  (rst_req_o),
  .irq_o      (irq_o),
  .line_rst_o (line_rst_o),
  .arm        (ctrl_q.arm),
  .rearm      (ctrl_q.rearm),
  .dual_arm   (dual_arm),
  .key_err    (key_err_q)
);

// File: tb/wdog_keyed_bench.sv
module wdog_keyed_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int NRST   = 8;
  localparam int NVEC   = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              rst_req, ext_rst, irq;
  logic [NRST-1:0]   lines;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // {we, write addr, write data, read addr, expected read}
  localparam logic [80:0] VECS [0:NVEC-1] = '{
    {1'b1, 8'h04, 32'h0000_0068, 8'h04, 32'h0000_0068},
    {1'b1, 8'h04, 32'h0000_00A9, 8'h04, 32'h0000_0068},
    {1'b0, 8'h00, 32'h0000_0000, 8'h00, 32'h8000_0000},
    {1'b1, 8'h00, 32'h2200_0046, 8'h00, 32'h8000_0046},
    {1'b1, 8'h00, 32'h2100_0001, 8'h00, 32'h8000_0046},
    {1'b1, 8'h18, 32'h8800_00A5, 8'h18, 32'h0000_00A5},
    {1'b1, 8'h18, 32'h8700_00FF, 8'h18, 32'h0000_00A5},
    {1'b1, 8'h18, 32'h8800_0081, 8'h18, 32'h0000_0081},
    {1'b1, 8'h08, 32'h0000_1234, 8'h08, 32'h0000_0000},
    {1'b1, 8'h04, 32'h0000_0048, 8'h04, 32'h0000_0048}
  };
  string tags [0:NVEC-1] = '{"R3", "R3", "R2", "R1", "R1",
                             "R10", "R10", "R10", "R5", "R3"};

  wdog_keyed #(.ADDR_W(ADDR_W), .LEN_W(6), .UNIT_TICKS(4),
               .HOLD_TICKS(16), .NRST(NRST)) u_wdog_keyed (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req_o(rst_req), .ext_rst_o(ext_rst), .irq_o(irq), .line_rst_o(lines)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // One tick every four clocks, changed on the falling edge
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick <= (tdiv == 0);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h, expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wt(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got hang, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(8'h00, r); check("R12", r, 32'h0);
    rd(8'h04, r); check("R12", r, 32'h0000_07E8);
    check("R12", {29'd0, rst_req, irq, ext_rst}, 32'h1);
    check("R12", 32'(lines), 32'h0);

    // Register vectors
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i][80]) wr(VECS[i][79:72], VECS[i][71:40]);
      rd(VECS[i][39:32], r);
      check(tags[i], r, VECS[i][31:0]);
    end
    check("R10", 32'(lines), 32'h81);

    // R4 single-stage expiry (two-stage set but irq disabled), R9 active-high pin
    wr(8'h00, 32'h2200_0047);
    wt(7); check("R4", {30'd0, rst_req, ext_rst}, 32'h0);
    wt(1); check("R4", 32'(rst_req), 32'h1);
    check("R7", 32'(irq), 32'h0);
    check("R9", 32'(ext_rst), 32'h1);
    wt(15); check("R6", 32'(rst_req), 32'h1);
    wt(1);  check("R6", 32'(rst_req), 32'h0);
    rd(8'h00, r); check("R6", r, 32'h8000_0046);

    // R5 wrong kick value ignored
    wr(8'h00, 32'h2200_0047);
    wt(6); wr(8'h08, 32'h0000_1970);
    wt(1); check("R5", 32'(rst_req), 32'h0);
    wt(1); check("R5", 32'(rst_req), 32'h1);
    wt(16);
    // R5 valid kick restarts
    wr(8'h00, 32'h2200_0047);
    wt(6); wr(8'h08, 32'h0000_1971);
    wt(7); check("R5", 32'(rst_req), 32'h0);
    wt(1); check("R5", 32'(rst_req), 32'h1);
    wt(16);

    // R3 new length waits for next arming
    wr(8'h00, 32'h2200_0047);
    wt(6); wr(8'h04, 32'h0000_0088);
    wt(1); check("R3", 32'(rst_req), 32'h0);
    wt(1); check("R3", 32'(rst_req), 32'h1);
    wt(16);
    wr(8'h00, 32'h2200_0047);
    wt(15); check("R3", 32'(rst_req), 32'h0);
    wt(1);  check("R3", 32'(rst_req), 32'h1);
    wt(16);
    wr(8'h04, 32'h0000_0048);

    // R7 two-stage
    wr(8'h00, 32'h2200_004F);
    wt(7); check("R7", 32'(irq), 32'h0);
    wt(1); check("R7", {30'd0, irq, rst_req}, 32'h2);
    wt(7); check("R7", {30'd0, irq, rst_req}, 32'h2);
    wt(1); check("R7", {30'd0, irq, rst_req}, 32'h1);
    wt(16);
    wr(8'h00, 32'h2200_004F);
    wt(8); check("R7", 32'(irq), 32'h1);
    wr(8'h08, 32'h0000_1971); check("R7", 32'(irq), 32'h0);
    wt(7); check("R7", 32'(irq), 32'h0);
    wt(1); check("R7", {30'd0, irq, rst_req}, 32'h2);
    wr(8'h00, 32'h2200_004E); check("R7", 32'(irq), 32'h0);
    wt(20); check("R7", 32'(rst_req), 32'h0);

    // R8 command reset, R9 active-low pin
    wr(8'h00, 32'h2200_0004); check("R9", 32'(ext_rst), 32'h1);
    wr(8'h14, 32'h0000_1208); check("R8", 32'(rst_req), 32'h0);
    wr(8'h14, 32'h0000_1209); check("R8", 32'(rst_req), 32'h1);
    check("R9", 32'(ext_rst), 32'h0);
    wt(15); check("R8", 32'(rst_req), 32'h1);
    wt(1);  check("R8", {30'd0, rst_req, ext_rst}, 32'h1);
    wr(8'h00, 32'h2200_0000);
    wr(8'h14, 32'h0000_1209);
    check("R9", {30'd0, rst_req, ext_rst}, 32'h3);
    wt(16);

    // R11 re-arm
    wr(8'h00, 32'h2200_0011);
    wt(8);  check("R11", 32'(rst_req), 32'h1);
    wt(16); check("R11", 32'(rst_req), 32'h0);
    rd(8'h00, r); check("R11", r, 32'h8000_0011);
    wt(7); check("R11", 32'(rst_req), 32'h0);
    wt(1); check("R11", 32'(rst_req), 32'h1);
    wr(8'h00, 32'h2200_0000);
    wt(16); check("R11", 32'(rst_req), 32'h0);
    wt(12); check("R11", 32'(rst_req), 32'h0);

    finish_run();
  end

endmodule